// File: doc/BRIEF.md
# Masked-Write Transmitter PHY Control Bank

This block is a bank of 16-bit control words that sits on a simple 32-bit register bus and drives the static configuration pins of a display-link transmitter PHY. Every bus write carries both the new data and a per-bit enable mask. Software can therefore change a single field, such as one lane's emphasis setting, without reading the word back first, and without disturbing a field that another agent is changing.

The bank has twelve control words and two read-only status words. The control fields are decoded straight onto output ports. They cover lane idle and power-down, PLL power-down and dividers, rate and termination selection, per-lane emphasis, amplitude and amplitude scale, spread-spectrum settings, and auxiliary-channel settings. Bit 0 of the first status word reports the PLL-ready input. Read data is registered and stays on the bus until the next read.

Top module: `pbk_phy_ctl_bank`

## Requirements
- R1: A write stores data from `bus_wdata[15:0]` using the enable mask in `bus_wdata[31:16]`. A register bit takes the new data only where its mask bit is 1. The affected outputs show the new value just after the clock edge that samples `bus_wr`. Cycles without a write, and writes with an all-zero mask, leave every output unchanged.
- R2: Control word n sits at byte offset 4·n, for n from 0 to 11 (offsets 0x00 to 0x2C). An offset whose two low bits are not both zero is unmapped.
- R3: Word 0x00 drives `lane_idle_o` from [11:8], `lane_pd_o` from [7:4], `iddq_en_o` from bit 1 and `pll_pd_o` from bit 0.
- R4: Word 0x04 drives `pll_div_o` from [14:0]. Word 0x08 drives `term_sel_o` from [10:8], `rate_sel_o` from [5:4] and `ref_div_o` from [3:0].
- R5: For lane L (0 to 3): emphasis is word 0x0C bits [4L+3:4L], output on `lane_emph_o[4L+3:4L]`. Amplitude is word 0x10 bits [4L+2:4L], output on `lane_amp_o[3L+2:3L]`. Amplitude scale is word 0x14 bits [2L+1:2L], output on `lane_scale_o[2L+1:2L]`. `tx_mode_o` comes from word 0x14 [9:8].
- R6: Word 0x18 drives `ssc_depth_o` from [15:12], `ssc_en_o` from bit 11 and `ssc_cnt_o` from [9:0]. Words 0x1C, 0x20 and 0x24 drive `spare_ctl_o`, `pll_ctl_hi_o` and `tx_ctl_o` with all 16 bits. Word 0x28 drives `aux_rx_pd_sel_o` from bit 5, `aux_tx_pd_sel_o` from bit 4, `aux_idle_o` from bit 2, `aux_rx_pd_o` from bit 1 and `aux_tx_pd_o` from bit 0. Word 0x2C drives `aux_vcm_o` from [14:12], `aux_mode_o` from [11:10], `aux_scale_o` from [9:8], `aux_amp_o` from [6:4] and `aux_term_o` from [2:0].
- R7: Bits that belong to no field are not stored and always read back as zero.
- R8: A read sampled at a clock edge puts the addressed word on `bus_rdata` just after that edge, and the value holds until the next read. A read and a write in the same cycle return the value from before the write. `bus_rdata[31:16]` is always zero.
- R9: Reading offset 0x30 returns `pll_ready_i` as sampled at the read edge in bit 0, with zeros elsewhere. Reading offset 0x34 returns zero.
- R10: Writes to 0x30, 0x34, unaligned offsets or any offset above 0x34 change nothing. Reads of unmapped offsets return zero.
- R11: After reset, word 0x00 reads 0x0FF1: all lanes idle and powered down, PLL powered down. Every other control word reads zero, and `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | [31:16] bit enables, [15:0] data |
| bus_rdata | output | 32 | Registered read data |
| pll_ready_i | input | 1 | PLL lock indication |
| lane_idle_o | output | 4 | Per-lane idle |
| lane_pd_o | output | 4 | Per-lane power-down |
| iddq_en_o | output | 1 | Quiescent-current test enable |
| pll_pd_o | output | 1 | PLL power-down |
| pll_div_o | output | 15 | PLL feedback divider |
| term_sel_o | output | 3 | Termination select |
| rate_sel_o | output | 2 | Link rate select |
| ref_div_o | output | 4 | Reference divider |
| lane_emph_o | output | 16 | Per-lane emphasis, 4 bits per lane |
| lane_amp_o | output | 12 | Per-lane amplitude, 3 bits per lane |
| lane_scale_o | output | 8 | Per-lane amplitude scale, 2 bits per lane |
| tx_mode_o | output | 2 | Transmit mode |
| ssc_depth_o | output | 4 | Spread-spectrum depth |
| ssc_en_o | output | 1 | Spread-spectrum enable |
| ssc_cnt_o | output | 10 | Spread-spectrum count |
| spare_ctl_o | output | 16 | General control word |
| pll_ctl_hi_o | output | 16 | PLL control upper word |
| tx_ctl_o | output | 16 | Transmitter control word |
| aux_rx_pd_sel_o | output | 1 | AUX receiver power-down source select |
| aux_tx_pd_sel_o | output | 1 | AUX driver power-down source select |
| aux_idle_o | output | 1 | AUX idle |
| aux_rx_pd_o | output | 1 | AUX receiver power-down |
| aux_tx_pd_o | output | 1 | AUX driver power-down |
| aux_vcm_o | output | 3 | AUX receiver common-mode |
| aux_mode_o | output | 2 | AUX mode |
| aux_scale_o | output | 2 | AUX amplitude scale |
| aux_amp_o | output | 3 | AUX amplitude |
| aux_term_o | output | 3 | AUX termination |

## Verification
The properties assume that `pll_ready_i` is already synchronous to `clk`. They also assume that one agent owns the bus, so at most one access of each kind arrives per cycle and the strobes carry no X after reset. The stimulus drives every input from the bench only, away from the active edge, with a known value in every cycle. It moves `pll_ready_i` only between cycles. Random traffic mixes aligned, unaligned, status and out-of-range offsets with arbitrary masks, including reads and writes in the same cycle.

// File: rtl/pbk_pkg.sv
package pbk_pkg;
    localparam int REG_W     = 16;
    localparam int BUS_W     = 32;
    localparam int NUM_CTRL  = 12;
    localparam int NUM_STAT  = 2;
    localparam int NUM_LANES = 4;
    localparam int IDX_W     = $clog2(NUM_CTRL + NUM_STAT);
    localparam int EMPH_W    = 4;
    localparam int AMP_W     = 3;
    localparam int SCALE_W   = 2;
    localparam int LANE_PITCH = 4;

    // word indices (offset / 4)
    localparam int W_TXPWR  = 0;
    localparam int W_PLLDIV = 1;
    localparam int W_CLKSEL = 2;
    localparam int W_EMPH   = 3;
    localparam int W_AMP    = 4;
    localparam int W_SCALE  = 5;
    localparam int W_SSC    = 6;
    localparam int W_SPARE  = 7;
    localparam int W_PLLHI  = 8;
    localparam int W_TXCTL  = 9;
    localparam int W_AUXPWR = 10;
    localparam int W_AUXCFG = 11;

    typedef enum logic [1:0] {ACC_NONE, ACC_CTRL, ACC_STAT} acc_kind_e;

    typedef struct packed {
        acc_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } decode_t;

    typedef logic [NUM_CTRL-1:0][REG_W-1:0] ctrl_words_t;

    function automatic logic [REG_W-1:0] span(int hi, int lo);
        logic [31:0] t;
        t = ((32'd1 << (hi - lo + 1)) - 32'd1) << lo;
        return t[REG_W-1:0];
    endfunction

    // bits of each control word that hold a field
    function automatic logic [REG_W-1:0] impl_mask(int idx);
        logic [REG_W-1:0] m;
        m = '0;
        case (idx)
            W_TXPWR:  m = span(11, 8) | span(7, 4) | span(1, 1) | span(0, 0);
            W_PLLDIV: m = span(14, 0);
            W_CLKSEL: m = span(10, 8) | span(5, 4) | span(3, 0);
            W_EMPH:   m = span(15, 0);
            W_AMP: begin
                for (int l = 0; l < NUM_LANES; l++)
                    m |= span(LANE_PITCH * l + AMP_W - 1, LANE_PITCH * l);
            end
            W_SCALE:  m = span(9, 8) | span(2 * NUM_LANES - 1, 0);
            W_SSC:    m = span(15, 12) | span(11, 11) | span(9, 0);
            W_SPARE, W_PLLHI, W_TXCTL: m = span(15, 0);
            W_AUXPWR: m = span(5, 4) | span(2, 0);
            W_AUXCFG: m = span(14, 12) | span(11, 10) | span(9, 8) | span(6, 4) | span(2, 0);
            default:  m = '0;
        endcase
        return m;
    endfunction

    function automatic ctrl_words_t reset_words();
        ctrl_words_t w;
        w = '0;
        w[W_TXPWR] = span(11, 4) | span(0, 0);
        return w;
    endfunction
endpackage

// File: rtl/pbk_addr_decode.sv
module pbk_addr_decode
    import pbk_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output decode_t           dec_o
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              aligned;

    assign word    = addr_i[ADDR_W-1:2];
    assign aligned = (addr_i[1:0] == 2'b00);

    always_comb begin
        dec_o.kind = ACC_NONE;
        dec_o.idx  = '0;
        if (aligned && (int'(word) < NUM_CTRL)) begin
            dec_o.kind = ACC_CTRL;
            dec_o.idx  = IDX_W'(word);
        end else if (aligned && (int'(word) < NUM_CTRL + NUM_STAT)) begin
            dec_o.kind = ACC_STAT;
            dec_o.idx  = IDX_W'(int'(word) - NUM_CTRL);
        end
    end
endmodule

// File: rtl/pbk_ctrl_store.sv
module pbk_ctrl_store
    import pbk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  decode_t          dec_i,
    input  logic [REG_W-1:0] wr_data,
    input  logic [REG_W-1:0] wr_mask,
    output ctrl_words_t      words_o
);
    typedef struct packed {
        ctrl_words_t word;
    } store_t;

    localparam ctrl_words_t RST_WORDS = reset_words();

    store_t      st_d, st_q;
    ctrl_words_t bit_en;

    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_en
        assign bit_en[i] = (wr_en && dec_i.kind == ACC_CTRL && dec_i.idx == IDX_W'(i))
                           ? (wr_mask & impl_mask(i)) : '0;
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_CTRL; i++)
            st_d.word[i] = (st_q.word[i] & ~bit_en[i]) | (wr_data & bit_en[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.word <= RST_WORDS;
        else        st_q <= st_d;
    end

    assign words_o = st_q.word;
endmodule

// File: rtl/pbk_read_port.sv
module pbk_read_port
    import pbk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  decode_t          dec_i,
    input  ctrl_words_t      words_i,
    input  logic             pll_ready_i,
    output logic [BUS_W-1:0] rdata_o
);
    typedef struct packed {
        logic [BUS_W-1:0] rdata;
    } rd_t;

    rd_t              rd_d, rd_q;
    logic [REG_W-1:0] sel;

    always_comb begin
        sel = '0;
        case (dec_i.kind)
            ACC_CTRL: begin
                for (int i = 0; i < NUM_CTRL; i++)
                    if (dec_i.idx == IDX_W'(i)) sel = words_i[i];
            end
            ACC_STAT: begin
                if (dec_i.idx == '0) sel = {{(REG_W-1){1'b0}}, pll_ready_i};
            end
            default: sel = '0;
        endcase
        rd_d = rd_q;
        if (rd_en) rd_d.rdata = {{(BUS_W-REG_W){1'b0}}, sel};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata_o = rd_q.rdata;
endmodule

// File: rtl/pbk_field_map.sv
module pbk_field_map
    import pbk_pkg::*;
(
    input  ctrl_words_t                    words_i,
    output logic [NUM_LANES-1:0]           lane_idle_o,
    output logic [NUM_LANES-1:0]           lane_pd_o,
    output logic                           iddq_en_o,
    output logic                           pll_pd_o,
    output logic [14:0]                    pll_div_o,
    output logic [2:0]                     term_sel_o,
    output logic [1:0]                     rate_sel_o,
    output logic [3:0]                     ref_div_o,
    output logic [NUM_LANES*EMPH_W-1:0]    lane_emph_o,
    output logic [NUM_LANES*AMP_W-1:0]     lane_amp_o,
    output logic [NUM_LANES*SCALE_W-1:0]   lane_scale_o,
    output logic [1:0]                     tx_mode_o,
    output logic [3:0]                     ssc_depth_o,
    output logic                           ssc_en_o,
    output logic [9:0]                     ssc_cnt_o,
    output logic [REG_W-1:0]               spare_ctl_o,
    output logic [REG_W-1:0]               pll_ctl_hi_o,
    output logic [REG_W-1:0]               tx_ctl_o,
    output logic                           aux_rx_pd_sel_o,
    output logic                           aux_tx_pd_sel_o,
    output logic                           aux_idle_o,
    output logic                           aux_rx_pd_o,
    output logic                           aux_tx_pd_o,
    output logic [2:0]                     aux_vcm_o,
    output logic [1:0]                     aux_mode_o,
    output logic [1:0]                     aux_scale_o,
    output logic [2:0]                     aux_amp_o,
    output logic [2:0]                     aux_term_o
);
    logic [REG_W-1:0] w_pwr, w_clk, w_scale, w_ssc, w_auxp, w_auxc;

    assign w_pwr   = words_i[W_TXPWR];
    assign w_clk   = words_i[W_CLKSEL];
    assign w_scale = words_i[W_SCALE];
    assign w_ssc   = words_i[W_SSC];
    assign w_auxp  = words_i[W_AUXPWR];
    assign w_auxc  = words_i[W_AUXCFG];

    assign lane_idle_o = w_pwr[8 +: NUM_LANES];
    assign lane_pd_o   = w_pwr[4 +: NUM_LANES];
    assign iddq_en_o   = w_pwr[1];
    assign pll_pd_o    = w_pwr[0];

    assign pll_div_o  = words_i[W_PLLDIV][14:0];
    assign term_sel_o = w_clk[10:8];
    assign rate_sel_o = w_clk[5:4];
    assign ref_div_o  = w_clk[3:0];

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        assign lane_emph_o[l*EMPH_W +: EMPH_W]    = words_i[W_EMPH][l*LANE_PITCH +: EMPH_W];
        assign lane_amp_o[l*AMP_W +: AMP_W]       = words_i[W_AMP][l*LANE_PITCH +: AMP_W];
        assign lane_scale_o[l*SCALE_W +: SCALE_W] = w_scale[l*SCALE_W +: SCALE_W];
    end
    assign tx_mode_o = w_scale[9:8];

    assign ssc_depth_o = w_ssc[15:12];
    assign ssc_en_o    = w_ssc[11];
    assign ssc_cnt_o   = w_ssc[9:0];

    assign spare_ctl_o  = words_i[W_SPARE];
    assign pll_ctl_hi_o = words_i[W_PLLHI];
    assign tx_ctl_o     = words_i[W_TXCTL];

    assign aux_rx_pd_sel_o = w_auxp[5];
    assign aux_tx_pd_sel_o = w_auxp[4];
    assign aux_idle_o      = w_auxp[2];
    assign aux_rx_pd_o     = w_auxp[1];
    assign aux_tx_pd_o     = w_auxp[0];

    assign aux_vcm_o   = w_auxc[14:12];
    assign aux_mode_o  = w_auxc[11:10];
    assign aux_scale_o = w_auxc[9:8];
    assign aux_amp_o   = w_auxc[6:4];
    assign aux_term_o  = w_auxc[2:0];
endmodule

// File: rtl/pbk_phy_ctl_bank.sv
module pbk_phy_ctl_bank
    import pbk_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              pll_ready_i,
    output logic [3:0]        lane_idle_o,
    output logic [3:0]        lane_pd_o,
    output logic              iddq_en_o,
    output logic              pll_pd_o,
    output logic [14:0]       pll_div_o,
    output logic [2:0]        term_sel_o,
    output logic [1:0]        rate_sel_o,
    output logic [3:0]        ref_div_o,
    output logic [15:0]       lane_emph_o,
    output logic [11:0]       lane_amp_o,
    output logic [7:0]        lane_scale_o,
    output logic [1:0]        tx_mode_o,
    output logic [3:0]        ssc_depth_o,
    output logic              ssc_en_o,
    output logic [9:0]        ssc_cnt_o,
    output logic [15:0]       spare_ctl_o,
    output logic [15:0]       pll_ctl_hi_o,
    output logic [15:0]       tx_ctl_o,
    output logic              aux_rx_pd_sel_o,
    output logic              aux_tx_pd_sel_o,
    output logic              aux_idle_o,
    output logic              aux_rx_pd_o,
    output logic              aux_tx_pd_o,
    output logic [2:0]        aux_vcm_o,
    output logic [1:0]        aux_mode_o,
    output logic [1:0]        aux_scale_o,
    output logic [2:0]        aux_amp_o,
    output logic [2:0]        aux_term_o
);
    decode_t     dec;
    ctrl_words_t words;

    pbk_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (bus_addr),
        .dec_o  (dec)
    );

    pbk_ctrl_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .dec_i   (dec),
        .wr_data (bus_wdata[REG_W-1:0]),
        .wr_mask (bus_wdata[BUS_W-1:REG_W]),
        .words_o (words)
    );

    pbk_read_port u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (bus_rd),
        .dec_i       (dec),
        .words_i     (words),
        .pll_ready_i (pll_ready_i),
        .rdata_o     (bus_rdata)
    );

    pbk_field_map u_map (
        .words_i         (words),
        .lane_idle_o     (lane_idle_o),
        .lane_pd_o       (lane_pd_o),
        .iddq_en_o       (iddq_en_o),
        .pll_pd_o        (pll_pd_o),
        .pll_div_o       (pll_div_o),
        .term_sel_o      (term_sel_o),
        .rate_sel_o      (rate_sel_o),
        .ref_div_o       (ref_div_o),
        .lane_emph_o     (lane_emph_o),
        .lane_amp_o      (lane_amp_o),
        .lane_scale_o    (lane_scale_o),
        .tx_mode_o       (tx_mode_o),
        .ssc_depth_o     (ssc_depth_o),
        .ssc_en_o        (ssc_en_o),
        .ssc_cnt_o       (ssc_cnt_o),
        .spare_ctl_o     (spare_ctl_o),
        .pll_ctl_hi_o    (pll_ctl_hi_o),
        .tx_ctl_o        (tx_ctl_o),
        .aux_rx_pd_sel_o (aux_rx_pd_sel_o),
        .aux_tx_pd_sel_o (aux_tx_pd_sel_o),
        .aux_idle_o      (aux_idle_o),
        .aux_rx_pd_o     (aux_rx_pd_o),
        .aux_tx_pd_o     (aux_tx_pd_o),
        .aux_vcm_o       (aux_vcm_o),
        .aux_mode_o      (aux_mode_o),
        .aux_scale_o     (aux_scale_o),
        .aux_amp_o       (aux_amp_o),
        .aux_term_o      (aux_term_o)
    );
endmodule

// File: rtl/pbk_bank_chk.sv
module pbk_bank_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              pll_ready_i,
    input logic [3:0]        lane_idle_o,
    input logic [3:0]        lane_pd_o,
    input logic              pll_pd_o,
    input logic [14:0]       pll_div_o,
    input logic              ssc_en_o
);
    // R1: no write means no control output moves
    p_hold_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable({lane_idle_o, lane_pd_o, pll_pd_o, pll_div_o, ssc_en_o}));

    // R1: an all-zero enable mask changes nothing
    p_zero_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_wdata[31:16] == 16'h0000)
        |=> $stable({lane_idle_o, lane_pd_o, pll_pd_o, pll_div_o, ssc_en_o}));

    // R3: fully enabled idle field follows the written data
    p_idle_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == '0 && bus_wdata[27:24] == 4'hF)
        |=> lane_idle_o == $past(bus_wdata[11:8]));

    // R8: upper read half is always zero
    p_rdata_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:16] == 16'h0000);

    // R9: status word mirrors PLL ready at the read edge
    p_pll_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'('h30))
        |=> bus_rdata == {31'd0, $past(pll_ready_i)});

    // R10: unaligned reads return zero
    p_unaligned_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[1:0] != 2'b00) |=> bus_rdata == 32'd0);

    // R11: leaving reset with lanes idle and powered down
    p_reset_state_r11: assert property (@(posedge clk)
        $rose(rst_n) |-> (lane_idle_o == 4'hF && lane_pd_o == 4'hF && pll_pd_o
                          && bus_rdata == 32'd0));
endmodule

bind pbk_phy_ctl_bank pbk_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .pll_ready_i (pll_ready_i),
    .lane_idle_o (lane_idle_o),
    .lane_pd_o   (lane_pd_o),
    .pll_pd_o    (pll_pd_o),
    .pll_div_o   (pll_div_o),
    .ssc_en_o    (ssc_en_o)
);

// File: tb/pbk_phy_ctl_bank_tb_top.sv
module pbk_phy_ctl_bank_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pll_ready = 1'b0;
    logic [3:0]  lane_idle_o, lane_pd_o, ref_div_o, ssc_depth_o;
    logic        iddq_en_o, pll_pd_o, ssc_en_o;
    logic [14:0] pll_div_o;
    logic [2:0]  term_sel_o, aux_vcm_o, aux_amp_o, aux_term_o;
    logic [1:0]  rate_sel_o, tx_mode_o, aux_mode_o, aux_scale_o;
    logic [15:0] lane_emph_o, spare_ctl_o, pll_ctl_hi_o, tx_ctl_o;
    logic [11:0] lane_amp_o;
    logic [7:0]  lane_scale_o;
    logic [9:0]  ssc_cnt_o;
    logic        aux_rx_pd_sel_o, aux_tx_pd_sel_o, aux_idle_o, aux_rx_pd_o, aux_tx_pd_o;

    pbk_phy_ctl_bank #(.ADDR_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pll_ready_i(pll_ready),
        .lane_idle_o(lane_idle_o), .lane_pd_o(lane_pd_o), .iddq_en_o(iddq_en_o),
        .pll_pd_o(pll_pd_o), .pll_div_o(pll_div_o), .term_sel_o(term_sel_o),
        .rate_sel_o(rate_sel_o), .ref_div_o(ref_div_o), .lane_emph_o(lane_emph_o),
        .lane_amp_o(lane_amp_o), .lane_scale_o(lane_scale_o), .tx_mode_o(tx_mode_o),
        .ssc_depth_o(ssc_depth_o), .ssc_en_o(ssc_en_o), .ssc_cnt_o(ssc_cnt_o),
        .spare_ctl_o(spare_ctl_o), .pll_ctl_hi_o(pll_ctl_hi_o), .tx_ctl_o(tx_ctl_o),
        .aux_rx_pd_sel_o(aux_rx_pd_sel_o), .aux_tx_pd_sel_o(aux_tx_pd_sel_o),
        .aux_idle_o(aux_idle_o), .aux_rx_pd_o(aux_rx_pd_o), .aux_tx_pd_o(aux_tx_pd_o),
        .aux_vcm_o(aux_vcm_o), .aux_mode_o(aux_mode_o), .aux_scale_o(aux_scale_o),
        .aux_amp_o(aux_amp_o), .aux_term_o(aux_term_o)
    );

    int checks = 0, fails = 0;
    bit done = 0;
    logic [15:0] m_ctrl [12];
    logic [31:0] m_rdata;

    // stored bits per control word, taken from the field lists in the requirements
    function automatic logic [15:0] field_bits(int i);
        case (i)
            0: return 16'h0FF3;  1: return 16'h7FFF;  2: return 16'h073F;
            3: return 16'hFFFF;  4: return 16'h7777;  5: return 16'h03FF;
            6: return 16'hFBFF;  10: return 16'h0037; 11: return 16'h7F77;
            7, 8, 9: return 16'hFFFF;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [31:0] bits(logic [15:0] v, int lo, int w);
        return 32'((v >> lo) & ((16'd1 << w) - 16'd1));
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 12; i++) m_ctrl[i] = 16'h0000;
        m_ctrl[0] = 16'h0FF1;
        m_rdata = 32'h0;
    endtask

    task automatic model_edge(logic wr, logic rd, logic [7:0] a, logic [31:0] wd, logic pll);
        int w;
        logic [15:0] msk;
        w = int'(a) / 4;
        if (rd) begin
            if (a[1:0] != 0) m_rdata = 0;
            else if (w < 12) m_rdata = {16'h0, m_ctrl[w]};
            else if (w == 12) m_rdata = {31'h0, pll};
            else m_rdata = 0;
        end
        if (wr && a[1:0] == 0 && w < 12) begin
            msk = wd[31:16] & field_bits(w);
            m_ctrl[w] = (m_ctrl[w] & ~msk) | (wd[15:0] & msk);
        end
    endtask

    task automatic compare_all();
        logic [15:0] e_emph;
        logic [11:0] e_amp;
        logic [7:0]  e_scale;
        for (int l = 0; l < 4; l++) begin
            e_emph[4*l +: 4]  = m_ctrl[3][4*l +: 4];
            e_amp[3*l +: 3]   = m_ctrl[4][4*l +: 3];
            e_scale[2*l +: 2] = m_ctrl[5][2*l +: 2];
        end
        chk("R3", "lane_idle", 32'(lane_idle_o), bits(m_ctrl[0], 8, 4));
        chk("R3", "lane_pd", 32'(lane_pd_o), bits(m_ctrl[0], 4, 4));
        chk("R3", "iddq", 32'(iddq_en_o), bits(m_ctrl[0], 1, 1));
        chk("R3", "pll_pd", 32'(pll_pd_o), bits(m_ctrl[0], 0, 1));
        chk("R4", "pll_div", 32'(pll_div_o), bits(m_ctrl[1], 0, 15));
        chk("R4", "clk fields", {term_sel_o, rate_sel_o, ref_div_o},
            {bits(m_ctrl[2], 8, 3), bits(m_ctrl[2], 4, 2), bits(m_ctrl[2], 0, 4)} & 32'h1FF
            | 32'(bits(m_ctrl[2], 8, 3) << 6 | bits(m_ctrl[2], 4, 2) << 4 | bits(m_ctrl[2], 0, 4)));
        chk("R5", "emphasis", 32'(lane_emph_o), 32'(e_emph));
        chk("R5", "amplitude", 32'(lane_amp_o), 32'(e_amp));
        chk("R5", "scale", 32'(lane_scale_o), 32'(e_scale));
        chk("R5", "tx_mode", 32'(tx_mode_o), bits(m_ctrl[5], 8, 2));
        chk("R6", "ssc", {ssc_depth_o, ssc_en_o, ssc_cnt_o},
            bits(m_ctrl[6], 12, 4) << 11 | bits(m_ctrl[6], 11, 1) << 10 | bits(m_ctrl[6], 0, 10));
        chk("R6", "spare", 32'(spare_ctl_o), 32'(m_ctrl[7]));
        chk("R6", "pll_hi", 32'(pll_ctl_hi_o), 32'(m_ctrl[8]));
        chk("R6", "tx_ctl", 32'(tx_ctl_o), 32'(m_ctrl[9]));
        chk("R6", "aux power", {aux_rx_pd_sel_o, aux_tx_pd_sel_o, aux_idle_o, aux_rx_pd_o, aux_tx_pd_o},
            bits(m_ctrl[10], 5, 1) << 4 | bits(m_ctrl[10], 4, 1) << 3 | bits(m_ctrl[10], 0, 3));
        chk("R6", "aux cfg", {aux_vcm_o, aux_mode_o, aux_scale_o, aux_amp_o, aux_term_o},
            bits(m_ctrl[11], 12, 3) << 10 | bits(m_ctrl[11], 10, 2) << 8 |
            bits(m_ctrl[11], 8, 2) << 6 | bits(m_ctrl[11], 4, 3) << 3 | bits(m_ctrl[11], 0, 3));
        chk("R8", "rdata", bus_rdata, m_rdata);
    endtask

    // drive one cycle, model the edge, compare at the following falling edge
    task automatic step(logic wr, logic rd, logic [7:0] a, logic [31:0] wd);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        @(posedge clk);
        model_edge(wr, rd, a, wd, pll_ready);
        @(negedge clk);
        compare_all();
        bus_wr = 0; bus_rd = 0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();
        chk("R11", "rdata after reset", bus_rdata, 32'h0);

        // R11: word 0 reset image
        step(0, 1, 8'h00, 0);
        chk("R11", "word0 reset read", bus_rdata, 32'h0000_0FF1);
        step(0, 1, 8'h18, 0);
        chk("R11", "word6 reset read", bus_rdata, 32'h0);

        // R1: clear idle only, power-down stays
        step(1, 0, 8'h00, 32'h0F00_0000);
        chk("R1", "idle cleared", 32'(lane_idle_o), 32'h0);
        chk("R1", "pd kept", 32'(lane_pd_o), 32'hF);
        // R1: zero mask ignored
        step(1, 0, 8'h00, 32'h0000_FFFF);
        chk("R1", "zero mask", 32'(lane_pd_o), 32'hF);

        // R2, R7: every word written with all ones reads back its field bits
        for (int i = 0; i < 12; i++) begin
            step(1, 0, 8'(4 * i), 32'hFFFF_FFFF);
            step(0, 1, 8'(4 * i), 0);
            chk("R7", $sformatf("word %0d readback", i), bus_rdata, 32'(field_bits(i)));
        end

        // R5: lane packing
        step(1, 0, 8'h0C, 32'hFFFF_4321);
        chk("R5", "emph lanes", 32'(lane_emph_o), 32'h4321);
        step(1, 0, 8'h10, 32'hFFFF_7531);
        chk("R5", "amp lanes", 32'(lane_amp_o), {20'h0, 3'd7, 3'd5, 3'd3, 3'd1});
        step(1, 0, 8'h14, 32'hFFFF_02E4);
        chk("R5", "scale lanes", 32'(lane_scale_o), 32'hE4);
        chk("R5", "tx mode", 32'(tx_mode_o), 32'h2);

        // R10: writes to status, unaligned and high offsets ignored
        step(1, 0, 8'h01, 32'hFFFF_0000);
        step(1, 0, 8'h30, 32'hFFFF_0000);
        step(1, 0, 8'h34, 32'hFFFF_0000);
        step(1, 0, 8'h80, 32'hFFFF_0000);
        step(0, 1, 8'h00, 0);
        chk("R10", "word0 untouched", bus_rdata, 32'h0000_0FF3);
        step(0, 1, 8'h02, 0);
        chk("R10", "unaligned read", bus_rdata, 32'h0);
        step(0, 1, 8'h44, 0);
        chk("R10", "high read", bus_rdata, 32'h0);

        // R9: status words
        pll_ready = 1;
        step(0, 1, 8'h30, 0);
        chk("R9", "pll ready 1", bus_rdata, 32'h1);
        pll_ready = 0;
        step(0, 1, 8'h30, 0);
        chk("R9", "pll ready 0", bus_rdata, 32'h0);
        pll_ready = 1;
        step(0, 1, 8'h34, 0);
        chk("R9", "second status", bus_rdata, 32'h0);

        // R8: same-cycle read and write returns old value, then holds
        step(1, 1, 8'h04, 32'hFFFF_1234);
        chk("R8", "read before write", bus_rdata, 32'h0000_7FFF);
        step(0, 0, 8'h00, 0);
        chk("R8", "rdata held", bus_rdata, 32'h0000_7FFF);
        step(0, 1, 8'h04, 0);
        chk("R4", "divider value", 32'(pll_div_o), 32'h1234);

        // random traffic with the cycle model compared every cycle
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] a;
            a = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'($urandom_range(0, 63));
            pll_ready = 1'($urandom);
            step(1'($urandom), 1'($urandom), a, $urandom);
        end

        done = 1;
        summary();
        $finish;
    end
endmodule